// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiply Unit with Flush and Canonical-NaN Modes

This block multiplies two IEEE 754 binary32 operands and rounds the product to nearest, ties to even. The same datapath also performs three bit-level operations on the first operand: absolute value, negation and plain move. Two mode bits in an internal control/status word change how arithmetic is handled. One mode flushes denormal operands and tiny results to zero. The other replaces every NaN result with one canonical encoding. The bit-level operations ignore both modes.

Each accepted operation produces its result one clock later. Exception flags collect in the same control/status word. They stay set until software rewrites the word through the write port. The write port also sets the mode bits. The unit has no backpressure: one operation can be accepted on every cycle.

Top module: `fpmul_unit`

## Requirements
- R1: With both modes off, a multiply of finite normal operands returns the product rounded to nearest-even, with sign = sign(a) XOR sign(b). The inexact flag (control bit 4) is set whenever rounding discards nonzero bits.
- R2: A product whose rounded magnitude does not fit the largest finite value returns a correctly signed infinity (exponent 0xFF, fraction 0). It sets the overflow flag (bit 2) and the inexact flag (bit 4).
- R3: With flush mode off, denormal operands take part at their exact value, and a tiny product is delivered as a denormal (gradual underflow). The underflow flag (bit 3) is set only when the tiny result is also inexact. A result counts as tiny when its exponent field is 0 after rounding.
- R4: With flush mode on (control bit 24), a denormal operand of a multiply is treated as a zero of the same sign, and the input-denormal flag (bit 7) is set.
- R5: With flush mode on, a multiply whose rounded result would be tiny returns a zero carrying the sign of the exact product. It sets the underflow flag (bit 3) and not the inexact flag.
- R6: With canonical-NaN mode off, a multiply with a NaN operand returns a NaN in this order of preference: a signalling a (quieted by setting fraction bit 22), then a signalling b (quieted), then a quiet a, then a quiet b. A signalling operand sets the invalid flag (bit 0).
- R7: With canonical-NaN mode on (control bit 25), any multiply with a NaN operand returns 0x7FC00000. Fraction payloads are discarded, and the invalid flag is still set for a signalling operand.
- R8: Infinity times zero, in either operand order, returns 0x7FC00000 and sets the invalid flag. Infinity times a finite nonzero value returns an infinity with the product sign and raises no flag.
- R9: The opcode selects the operation: 0 multiplies, 1 clears bit 31 of a, 2 inverts bit 31 of a, 3 passes a unchanged. Opcodes 1 to 3 keep NaN payloads, never flush, ignore both modes and leave every flag unchanged.
- R10: A result appears on `res_word` with `res_valid` high exactly one cycle after `op_valid`. Flags are sticky. They are changed only by a write through `cfg_wr`, which loads bits 25, 24, 7, 4, 3, 2 and 0 of `cfg_wdata`; all other control bits read 0.
- R11: Synchronous reset clears the control word, the result and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op_code | input | 2 | 0 multiply, 1 absolute value, 2 negate, 3 move |
| src_a | input | 32 | First operand (the only operand of opcodes 1 to 3) |
| src_b | input | 32 | Second operand |
| cfg_wr | input | 1 | Load the control/status word from cfg_wdata |
| cfg_wdata | input | 32 | Write data for the control/status word |
| cfg_word | output | 32 | Control/status word: modes in bits 25 and 24, flags in bits 7, 4, 3, 2 and 0 |
| res_valid | output | 1 | Result valid, one cycle after op_valid |
| res_word | output | 32 | Result, held until the next operation |

## Verification
The bench builds the unit with its default format parameters: an 8-bit exponent and a 23-bit fraction. At these values every binary32 boundary encoding can be written directly as a hex constant. These include the smallest denormal, the smallest normal, the largest exponent, signalling and quiet NaN payloads, and exact rounding ties in both the normal and the denormal range. Each mode combination is then exercised against products whose expected encodings are worked out by hand. This makes the difference between flushing and gradual underflow, and between propagated and canonical NaNs, directly visible in the result bits and the sticky flags.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int PROD_W  = 2 * MANT_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    // control/status bit positions
    localparam int CB_INV = 0;
    localparam int CB_OVF = 2;
    localparam int CB_UNF = 3;
    localparam int CB_INX = 4;
    localparam int CB_IDN = 7;
    localparam int CB_FZ  = 24;
    localparam int CB_DN  = 25;

    localparam logic [31:0] FLAG_MASK = (32'd1 << CB_INV) | (32'd1 << CB_OVF) |
                                        (32'd1 << CB_UNF) | (32'd1 << CB_INX) |
                                        (32'd1 << CB_IDN);
    localparam logic [31:0] CTRL_WMASK = FLAG_MASK | (32'd1 << CB_FZ) | (32'd1 << CB_DN);

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_ABS = 2'd1,
        OP_NEG = 2'd2,
        OP_MOV = 2'd3
    } fpm_op_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic              sign;
        logic              is_zero;
        logic              is_inf;
        logic              is_nan;
        logic              is_snan;
        logic              flushed;
        logic [EXP_W-1:0]  eff_exp;
        logic [MANT_W-1:0] mant;
    } fp_class_t;

    typedef struct packed {
        logic inv;
        logic ovf;
        logic unf;
        logic inx;
        logic idn;
    } fpm_flags_t;

    localparam fp_word_t CANON_NAN = '{sign: 1'b0, exp: '1,
                                       frac: {1'b1, {(FRAC_W-1){1'b0}}}};

    function automatic fp_word_t quieten(input fp_word_t w);
        fp_word_t q;
        q = w;
        q.frac[FRAC_W-1] = 1'b1;
        return q;
    endfunction

    function automatic int lead_zeros(input logic [PROD_W-1:0] v);
        int n;
        n = PROD_W;
        for (int i = 0; i < PROD_W; i++) begin
            if (v[i]) n = PROD_W - 1 - i;
        end
        return n;
    endfunction

    function automatic logic [31:0] flags_to_word(input fpm_flags_t f);
        logic [31:0] w;
        w = '0;
        w[CB_INV] = f.inv;
        w[CB_OVF] = f.ovf;
        w[CB_UNF] = f.unf;
        w[CB_INX] = f.inx;
        w[CB_IDN] = f.idn;
        return w;
    endfunction

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
(
    input  fp_word_t  word,
    input  logic      flush_en,
    output fp_class_t cls
);
    logic exp_zero, frac_zero, exp_full, denorm;

    always_comb begin
        exp_zero  = (word.exp == '0);
        frac_zero = (word.frac == '0);
        exp_full  = (word.exp == '1);
        denorm    = exp_zero && !frac_zero;

        cls.sign    = word.sign;
        cls.flushed = flush_en && denorm;
        cls.is_zero = exp_zero && (frac_zero || cls.flushed);
        cls.is_inf  = exp_full && frac_zero;
        cls.is_nan  = exp_full && !frac_zero;
        cls.is_snan = cls.is_nan && !word.frac[FRAC_W-1];
        cls.eff_exp = exp_zero ? EXP_W'(1) : word.exp;
        cls.mant    = {!exp_zero, word.frac};
    end
endmodule

// File: rtl/fpm_special.sv
module fpm_special
    import fpm_pkg::*;
(
    input  fp_word_t  word_a,
    input  fp_word_t  word_b,
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    input  logic      canon_en,
    output logic      hit,
    output fp_word_t  word,
    output logic      invalid
);
    logic prod_sign, any_nan, inf_zero;

    always_comb begin
        prod_sign = cls_a.sign ^ cls_b.sign;
        any_nan   = cls_a.is_nan || cls_b.is_nan;
        inf_zero  = (cls_a.is_inf && cls_b.is_zero) || (cls_b.is_inf && cls_a.is_zero);
        hit       = 1'b1;
        invalid   = 1'b0;
        word      = '0;

        if (any_nan) begin
            invalid = cls_a.is_snan || cls_b.is_snan;
            if (canon_en)          word = CANON_NAN;
            else if (cls_a.is_snan) word = quieten(word_a);
            else if (cls_b.is_snan) word = quieten(word_b);
            else if (cls_a.is_nan)  word = word_a;
            else                    word = word_b;
        end else if (inf_zero) begin
            invalid = 1'b1;
            word    = CANON_NAN;
        end else if (cls_a.is_inf || cls_b.is_inf) begin
            word = '{sign: prod_sign, exp: '1, frac: '0};
        end else if (cls_a.is_zero || cls_b.is_zero) begin
            word = '{sign: prod_sign, exp: '0, frac: '0};
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/fpm_mul_core.sv
module fpm_mul_core
    import fpm_pkg::*;
(
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    input  logic      flush_en,
    output fp_word_t  word,
    output logic      ovf,
    output logic      unf,
    output logic      inx
);
    logic [PROD_W-1:0]   prod, norm, shifted, lost_mask;
    logic [MANT_W-1:0]   keep;
    logic                guard, sticky, round_up, inexact, tiny, big;
    logic [EXP_W-1:0]    exp_enc;
    logic [WORD_W-2:0]   pre, rounded;
    logic                sign;
    int                  lz, e_unb, sh;

    always_comb begin
        sign   = cls_a.sign ^ cls_b.sign;
        prod   = {{MANT_W{1'b0}}, cls_a.mant} * {{MANT_W{1'b0}}, cls_b.mant};
        lz     = lead_zeros(prod);
        norm   = prod << lz;
        e_unb  = int'(cls_a.eff_exp) + int'(cls_b.eff_exp) - (BIAS - 1) - lz;
        big    = (e_unb >= EXP_MAX);

        if (e_unb >= 1)              sh = 0;
        else if (1 - e_unb > PROD_W) sh = PROD_W;
        else                         sh = 1 - e_unb;

        shifted   = norm >> sh;
        lost_mask = ~({PROD_W{1'b1}} << sh);
        keep      = shifted[PROD_W-1 -: MANT_W];
        guard     = shifted[PROD_W-1-MANT_W];
        sticky    = (|shifted[PROD_W-2-MANT_W:0]) || (|(norm & lost_mask));
        inexact   = guard || sticky;
        round_up  = guard && (sticky || keep[0]);

        exp_enc   = (e_unb >= 1 && !big) ? e_unb[EXP_W-1:0] : '0;
        pre       = {exp_enc, keep[FRAC_W-1:0]};
        rounded   = pre + {{(WORD_W-2){1'b0}}, round_up};
        tiny      = (rounded[WORD_W-2 -: EXP_W] == '0);

        ovf  = 1'b0;
        unf  = 1'b0;
        inx  = 1'b0;
        word = {sign, rounded};
        if (big || rounded[WORD_W-2 -: EXP_W] == '1) begin
            ovf  = 1'b1;
            inx  = 1'b1;
            word = '{sign: sign, exp: '1, frac: '0};
        end else if (tiny && flush_en) begin
            unf  = 1'b1;
            word = '{sign: sign, exp: '0, frac: '0};
        end else begin
            inx = inexact;
            unf = tiny && inexact;
        end
    end
endmodule

// File: rtl/fpm_ctrl_reg.sv
module fpm_ctrl_reg
    import fpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        upd,
    input  fpm_flags_t  new_flags,
    output logic [31:0] ctrl
);
    logic [31:0] base;

    always_comb base = wr ? (wdata & CTRL_WMASK) : ctrl;

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= base | (upd ? flags_to_word(new_flags) : 32'd0);
    end
endmodule

// File: rtl/fpmul_unit.sv
module fpmul_unit
    import fpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [1:0]  op_code,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_word,
    output logic        res_valid,
    output logic [31:0] res_word
);
    fpm_op_e    op;
    logic       arith, fz_on, dn_on;
    fp_word_t   words [2];
    fp_class_t  cls   [2];
    fp_word_t   sp_word, core_word, next_word;
    logic       sp_hit, sp_inv, c_ovf, c_unf, c_inx;
    fpm_flags_t flags;

    always_comb begin
        op       = fpm_op_e'(op_code);
        arith    = (op == OP_MUL);
        fz_on    = cfg_word[CB_FZ];
        dn_on    = cfg_word[CB_DN];
        words[0] = src_a;
        words[1] = src_b;
    end

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpm_classify u_cls (
            .word     (words[g]),
            .flush_en (fz_on && arith),
            .cls      (cls[g])
        );
    end

    fpm_special u_special (
        .word_a   (words[0]),
        .word_b   (words[1]),
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .canon_en (dn_on),
        .hit      (sp_hit),
        .word     (sp_word),
        .invalid  (sp_inv)
    );

    fpm_mul_core u_core (
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .flush_en (fz_on),
        .word     (core_word),
        .ovf      (c_ovf),
        .unf      (c_unf),
        .inx      (c_inx)
    );

    always_comb begin
        flags     = '0;
        next_word = words[0];
        unique case (op)
            OP_ABS: next_word.sign = 1'b0;
            OP_NEG: next_word.sign = ~words[0].sign;
            OP_MOV: next_word = words[0];
            OP_MUL: begin
                flags.idn = cls[0].flushed || cls[1].flushed;
                if (sp_hit) begin
                    next_word = sp_word;
                    flags.inv = sp_inv;
                end else begin
                    next_word = core_word;
                    flags.ovf = c_ovf;
                    flags.unf = c_unf;
                    flags.inx = c_inx;
                end
            end
            default: next_word = words[0];
        endcase
    end

    fpm_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_wr),
        .wdata     (cfg_wdata),
        .upd       (op_valid && arith),
        .new_flags (flags),
        .ctrl      (cfg_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) res_word <= next_word;
        end
    end
endmodule

// File: rtl/fpmul_checks.sv
module fpmul_checks
    import fpm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [1:0]  op_code,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic        cfg_wr,
    input logic [31:0] cfg_word,
    input logic        res_valid,
    input logic [31:0] res_word
);
    function automatic logic nan_of(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != '0);
    endfunction

    logic mul_now;
    always_comb mul_now = op_valid && (op_code == OP_MUL);

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> ((cfg_word & $past(cfg_word) & FLAG_MASK) == ($past(cfg_word) & FLAG_MASK)));

    p_modes_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> (cfg_word[CB_DN:CB_FZ] == $past(cfg_word[CB_DN:CB_FZ])));

    p_canon_nan_r7: assert property (@(posedge clk) disable iff (rst)
        (mul_now && cfg_word[CB_DN] && (nan_of(src_a) || nan_of(src_b)))
        |=> (res_word == 32'h7FC00000));

    p_no_denorm_r5: assert property (@(posedge clk) disable iff (rst)
        (mul_now && cfg_word[CB_FZ])
        |=> !((res_word[30:23] == 8'h00) && (res_word[22:0] != '0)));

    p_inf_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (mul_now && !cfg_word[CB_FZ] && (src_a[30:0] == 31'h7F800000) && (src_b[30:0] == '0))
        |=> ((res_word == 32'h7FC00000) && cfg_word[CB_INV]));

    p_abs_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ABS) |=> (res_word == {1'b0, $past(src_a[30:0])}));

    p_bitop_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code != OP_MUL && !cfg_wr) |=> (cfg_word == $past(cfg_word)));

    p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cfg_word & ~CTRL_WMASK) == '0));
endmodule

bind fpmul_unit fpmul_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .src_a     (src_a),
    .src_b     (src_b),
    .cfg_wr    (cfg_wr),
    .cfg_word  (cfg_word),
    .res_valid (res_valid),
    .res_word  (res_word)
);

// File: tb/tb_fpmul_unit.sv
`timescale 1ns/1ps
module tb_fpmul_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_word;
    logic        res_valid;
    logic [31:0] res_word;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    fpmul_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_word(cfg_word), .res_valid(res_valid), .res_word(res_word)
    );

    localparam logic [1:0] MUL = 2'd0, ABS = 2'd1, NEG = 2'd2, MOV = 2'd3;
    localparam logic [31:0] FZ = 32'h0100_0000, DN = 32'h0200_0000;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, got, exp);
        end
    endtask

    task automatic write_ctrl(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic exec(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = 1'b1;
        op_code = op;
        src_a = a;
        src_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_mul(input string req, input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] res, input logic [31:0] ctrl);
        exec(MUL, a, b);
        check(req, "result", res_word, res);
        check(req, "ctrl", cfg_word, ctrl);
    endtask

    task automatic t_reset();
        check("R11", "ctrl after reset", cfg_word, 32'h0);
        check("R11", "valid after reset", {31'd0, res_valid}, 32'h0);
        check("R11", "result after reset", res_word, 32'h0);
    endtask

    task automatic t_normal();
        write_ctrl(32'h0);
        expect_mul("R1", 32'h3FC00000, 32'h40000000, 32'h40400000, 32'h0);
        expect_mul("R1", 32'hBF800000, 32'h40000000, 32'hC0000000, 32'h0);
        expect_mul("R1", 32'h3F800001, 32'h3F800001, 32'h3F800002, 32'h10);
        write_ctrl(32'h0);
        expect_mul("R1", 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 32'h10);
        expect_mul("R1", 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 32'h10);
    endtask

    task automatic t_overflow();
        write_ctrl(32'h0);
        expect_mul("R2", 32'h7F000000, 32'h40000000, 32'h7F800000, 32'h14);
        expect_mul("R2", 32'hFF000000, 32'h40000000, 32'hFF800000, 32'h14);
    endtask

    task automatic t_gradual();
        write_ctrl(32'h0);
        expect_mul("R3", 32'h00800000, 32'h3F000000, 32'h00400000, 32'h0);
        expect_mul("R3", 32'h00000001, 32'h40000000, 32'h00000002, 32'h0);
        expect_mul("R3", 32'h00000001, 32'h3F000000, 32'h00000000, 32'h18);
    endtask

    task automatic t_flush_in();
        write_ctrl(FZ);
        expect_mul("R4", 32'h00000001, 32'h40000000, 32'h00000000, FZ | 32'h80);
        expect_mul("R4", 32'h80000001, 32'h40000000, 32'h80000000, FZ | 32'h80);
    endtask

    task automatic t_flush_out();
        write_ctrl(FZ);
        expect_mul("R5", 32'h00800000, 32'h3F000000, 32'h00000000, FZ | 32'h08);
        expect_mul("R5", 32'h80800000, 32'h3F000000, 32'h80000000, FZ | 32'h08);
        expect_mul("R5", 32'h00800000, 32'h3F800000, 32'h00800000, FZ | 32'h08);
    endtask

    task automatic t_nan_prop();
        write_ctrl(32'h0);
        expect_mul("R6", 32'h3F800000, 32'h7FC12345, 32'h7FC12345, 32'h0);
        expect_mul("R6", 32'h7F800001, 32'h7FC00005, 32'h7FC00001, 32'h1);
        expect_mul("R6", 32'h7FC00007, 32'h7F800002, 32'h7FC00002, 32'h1);
    endtask

    task automatic t_canon_nan();
        write_ctrl(DN);
        expect_mul("R7", 32'h7FC12345, 32'h3F800000, 32'h7FC00000, DN);
        expect_mul("R7", 32'h3F800000, 32'h7F800001, 32'h7FC00000, DN | 32'h1);
    endtask

    task automatic t_inf_zero();
        write_ctrl(32'h0);
        expect_mul("R8", 32'h7F800000, 32'h40000000, 32'h7F800000, 32'h0);
        expect_mul("R8", 32'hFF800000, 32'h40000000, 32'hFF800000, 32'h0);
        expect_mul("R8", 32'h7F800000, 32'h00000000, 32'h7FC00000, 32'h1);
        expect_mul("R8", 32'h80000000, 32'hFF800000, 32'h7FC00000, 32'h1);
    endtask

    task automatic t_bitops();
        write_ctrl(FZ | DN);
        exec(ABS, 32'hFFC12345, 32'h0);
        check("R9", "abs nan", res_word, 32'h7FC12345);
        exec(NEG, 32'h00000001, 32'h0);
        check("R9", "neg denormal", res_word, 32'h80000001);
        exec(MOV, 32'h7F800001, 32'h0);
        check("R9", "mov snan", res_word, 32'h7F800001);
        exec(ABS, 32'h80000001, 32'h0);
        check("R9", "abs denormal", res_word, 32'h00000001);
        check("R9", "flags untouched", cfg_word, FZ | DN);
    endtask

    task automatic t_sticky();
        write_ctrl(32'h0);
        @(negedge clk);
        op_valid = 1'b1; op_code = MUL; src_a = 32'h3F800001; src_b = 32'h3F800001;
        @(negedge clk);
        op_valid = 1'b0;
        check("R10", "valid one cycle later", {31'd0, res_valid}, 32'h1);
        check("R10", "first flags", cfg_word, 32'h10);
        @(negedge clk);
        check("R10", "valid drops", {31'd0, res_valid}, 32'h0);
        check("R10", "result held", res_word, 32'h3F800002);
        expect_mul("R10", 32'h40000000, 32'h3F800000, 32'h40000000, 32'h10);
        write_ctrl(32'h0);
        check("R10", "write clears", cfg_word, 32'h0);
        write_ctrl(32'hFFFFFFFF);
        check("R10", "writable mask", cfg_word, 32'h0300009D);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11", "ctrl after late reset", cfg_word, 32'h0);
        check("R11", "result after late reset", res_word, 32'h0);
    endtask

    initial begin
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_overflow();
        t_gradual();
        t_flush_in();
        t_flush_out();
        t_nan_prop();
        t_canon_nan();
        t_inf_zero();
        t_bitops();
        t_sticky();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule